// File: doc/BRIEF.md
# Auto-Reload Underflow Down Timer

This block is a 16-bit down counter that produces periodic interrupt requests. Software writes a reload value as two separate bytes: a low byte and a high byte. It then sets a run bit and an interrupt-enable bit. While running, the counter steps down by one on each qualified count tick. When it steps from zero to all-ones, it copies the stored reload value into the counter and raises a sticky request flag. That flag stays set until a clear strobe arrives. A reload value of N therefore gives one request every N+1 ticks.

The count source is chosen at build time by a parameter. In the default variant, an input picks either a slow tick strobe or a fast tick strobe. In the divider variant, the block makes its own tick at two thirds of the system clock rate, which is the system clock divided by 1.5. The counter comes out of reset at zero. As a result, the first tick after the run bit is set wraps the counter at once, which raises a request and loads the reload value. Software is expected to write the reload bytes before it starts the timer.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0, and both the run bit and the interrupt-enable bit are 0.
- R2: While the run bit is 1, each qualified tick lowers `count` by exactly one. While the run bit is 0, ticks leave `count` unchanged.
- R3: In the default variant (DIV_MODE=0), `src_sel`=0 makes `slow_tick` the qualified tick and `src_sel`=1 makes `fast_tick` the qualified tick. The strobe that is not selected has no effect on `count`.
- R4: A qualified tick taken while `count` is 0 loads `count` with the reload value {high byte, low byte} and sets the request flag. A reload value of N gives one request every N+1 ticks.
- R5: Because `count` resets to 0, the first qualified tick after the run bit is set raises the request and loads the reload value.
- R6: `lo_we` writes `wdata` into the low reload byte and `hi_we` writes it into the high reload byte. Neither write changes `count` before the next reload.
- R7: The request flag is sticky, and `irq` equals the flag ANDed with the interrupt-enable bit. Clearing the interrupt-enable bit hides the flag without losing it.
- R8: `irq_clr` clears the request flag. If a wrap happens in the same cycle as `irq_clr`, the flag stays set.
- R9: In the divider variant (DIV_MODE=1), exactly two of every three consecutive clock cycles carry a qualified tick. In this variant, `src_sel`, `slow_tick` and `fast_tick` are ignored.
- R10: `cfg_we` loads `cfg_run` into the run bit and `cfg_irq_en` into the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_we | input | 1 | Write strobe for the low reload byte |
| hi_we | input | 1 | Write strobe for the high reload byte |
| wdata | input | 8 | Byte written by `lo_we` or `hi_we` |
| cfg_we | input | 1 | Write strobe for the run and interrupt-enable bits |
| cfg_run | input | 1 | Run bit value for `cfg_we` |
| cfg_irq_en | input | 1 | Interrupt-enable value for `cfg_we` |
| src_sel | input | 1 | Tick source select: 0 selects slow, 1 selects fast |
| slow_tick | input | 1 | Single-cycle slow count strobe |
| fast_tick | input | 1 | Single-cycle fast count strobe |
| irq_clr | input | 1 | Clears the request flag |
| count | output | 16 | Current counter value |
| irq | output | 1 | Interrupt request: flag ANDed with interrupt enable |

## Verification
Directed sequences first show the wrap that happens straight out of reset, with and without a clear strobe in the same cycle. They then step a small reload value through a full period, to tell an N+1 interval apart from an N interval. A reload write in the middle of a period shows whether the write leaks into the running count. Pulses on the tick strobe that is not selected, and ticks given while the run bit is 0, show whether the select and run gating work. After that, random strobes and small random reload values run against a bench model, which exposes frequent wraps and clear strobes in every mix. A separate divider-variant instance is run for a window of whole three-cycle groups, and the count it reaches shows whether the two-in-three tick density holds while the external strobes are ignored.

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int BYTE_W   = 8,
  parameter int DIV_MODE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                cfg_we,
  input  logic                cfg_run,
  input  logic                cfg_irq_en,
  input  logic                src_sel,
  input  logic                slow_tick,
  input  logic                fast_tick,
  input  logic                irq_clr,
  output logic [2*BYTE_W-1:0] count,
  output logic                irq
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] pre_lo, pre_hi;
  logic [CNT_W-1:0]  cnt;
  logic              run_q, ie_q, flag_q;
  logic              src_tick, tick, wrap;

  generate
    if (DIV_MODE != 0) begin : g_div
      logic [1:0] ph;
      always_ff @(posedge clk) begin
        if (!rst_n)            ph <= 2'd0;
        else if (ph == 2'd2)   ph <= 2'd0;
        else                   ph <= ph + 2'd1;
      end
      assign src_tick = (ph != 2'd2);

      AST_DIV_NO_GAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !src_tick |=> src_tick); // R9
      AST_DIV_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ph != 2'd3); // R9
    end else begin : g_sel
      assign src_tick = src_sel ? fast_tick : slow_tick;
    end
  endgenerate

  assign tick = src_tick & run_q;
  assign wrap = tick & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_lo <= '0;
      pre_hi <= '0;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (lo_we)  pre_lo <= wdata;
      if (hi_we)  pre_hi <= wdata;
      if (cfg_we) begin
        run_q <= cfg_run;
        ie_q  <= cfg_irq_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wrap)  cnt <= {pre_hi, pre_lo};
    else if (tick)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (irq_clr)  flag_q <= 1'b0;
  end

  assign count = cnt;
  assign irq   = flag_q & ie_q;

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> (count == $past(cnt) - 1'b1)); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(count)); // R2
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> (count == {$past(pre_hi), $past(pre_lo)})); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !irq_clr) |=> flag_q); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tick) |=> !flag_q); // R8
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick)); // R4

endmodule

// File: tb/reload_down_timer_tb.sv
module reload_down_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_we = 0, hi_we = 0, cfg_we = 0, cfg_run = 0, cfg_irq_en = 0;
  logic        src_sel = 0, slow_tick = 0, fast_tick = 0, irq_clr = 0;
  logic [7:0]  wdata = '0;
  logic [15:0] count;
  logic        irq;

  logic        d_lo_we = 0, d_hi_we = 0, d_cfg_we = 0, d_run = 0;
  logic [7:0]  d_wdata = '0;
  logic [15:0] d_count;
  logic        d_irq;

  int n_chk = 0, n_bad = 0, wd = 0;

  always #2 clk = ~clk;

  reload_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we), .wdata(wdata),
    .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_irq_en(cfg_irq_en),
    .src_sel(src_sel), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .irq_clr(irq_clr), .count(count), .irq(irq));

  reload_down_timer #(.DIV_MODE(1)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .lo_we(d_lo_we), .hi_we(d_hi_we), .wdata(d_wdata),
    .cfg_we(d_cfg_we), .cfg_run(d_run), .cfg_irq_en(1'b0),
    .src_sel(1'b0), .slow_tick(1'b0), .fast_tick(1'b0),
    .irq_clr(1'b0), .count(d_count), .irq(d_irq));

  // reference model of the requirements
  logic [15:0] m_cnt, m_pre;
  logic        m_run, m_ie, m_flag;

  function automatic logic m_tick(logic run, logic sel, logic s, logic f);
    return run && (sel ? f : s);
  endfunction

  function automatic logic [15:0] m_next(logic [15:0] c, logic [15:0] p, logic t);
    if (!t) return c;
    return (c == 16'd0) ? p : c - 16'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pre <= 0; m_run <= 0; m_ie <= 0; m_flag <= 0;
    end else begin
      logic t;
      t = m_tick(m_run, src_sel, slow_tick, fast_tick);
      m_cnt <= m_next(m_cnt, m_pre, t);
      if (t && m_cnt == 0) m_flag <= 1'b1;
      else if (irq_clr)    m_flag <= 1'b0;
      if (lo_we)  m_pre[7:0]  <= wdata;
      if (hi_we)  m_pre[15:8] <= wdata;
      if (cfg_we) begin m_run <= cfg_run; m_ie <= cfg_irq_en; end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    lo_we = 0; hi_we = 0; cfg_we = 0; slow_tick = 0; fast_tick = 0; irq_clr = 0;
    d_lo_we = 0; d_hi_we = 0; d_cfg_we = 0;
  endtask

  task automatic set_pre(input logic [15:0] v);
    lo_we = 1; wdata = v[7:0]; step();
    hi_we = 1; wdata = v[15:8]; step();
  endtask

  task automatic set_cfg(input logic run, input logic ie);
    cfg_we = 1; cfg_run = run; cfg_irq_en = ie; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin slow_tick = 1; step(); end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    slow_tick = 1; step();
    chk("R1 run off no count", count, 16'h0000);
    chk("R1 flag clear", {15'd0, irq}, 16'd0);

    set_pre(16'h0005);
    chk("R6 write no effect", count, 16'h0000);
    set_cfg(1, 1);
    chk("R10 cfg load holds count", count, 16'h0000);
    slow_tick = 1; irq_clr = 1; step();
    chk("R5 first tick reload", count, 16'h0005);
    chk("R8 wrap beats clear", {15'd0, irq}, 16'd1);
    irq_clr = 1; step();
    chk("R8 clear", {15'd0, irq}, 16'd0);

    fast_tick = 1; step(); fast_tick = 1; step();
    chk("R3 unselected ignored", count, 16'h0005);
    ticks(1);
    chk("R2 one step", count, 16'h0004);
    ticks(4);
    chk("R4 reach zero", count, 16'h0000);
    chk("R4 no early irq", {15'd0, irq}, 16'd0);
    ticks(1);
    chk("R4 period N+1 reload", count, 16'h0005);
    chk("R4 period N+1 irq", {15'd0, irq}, 16'd1);
    irq_clr = 1; step();

    src_sel = 1;
    slow_tick = 1; step();
    chk("R3 slow ignored when fast sel", count, 16'h0005);
    fast_tick = 1; step();
    chk("R3 fast selected", count, 16'h0004);
    src_sel = 0;

    set_pre(16'h0102);
    chk("R6 mid-period write", count, 16'h0004);
    ticks(4);
    chk("R6 old period kept", count, 16'h0000);
    ticks(1);
    chk("R6 new value on reload", count, 16'h0102);

    set_cfg(1, 0);
    chk("R7 masked", {15'd0, irq}, 16'd0);
    set_cfg(1, 1);
    chk("R7 flag retained", {15'd0, irq}, 16'd1);
    irq_clr = 1; step();

    set_cfg(0, 1);
    ticks(3);
    chk("R2 stopped hold", count, 16'h0102);
    set_cfg(1, 1);
    set_pre(16'h0003);

    for (int i = 0; i < 3000; i++) begin
      slow_tick = ($urandom_range(0, 2) != 0);
      fast_tick = ($urandom_range(0, 1) != 0);
      src_sel   = ($urandom_range(0, 7) == 0);
      irq_clr   = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 19) == 0) begin lo_we = 1; wdata = 8'($urandom_range(0, 9)); end
      else if ($urandom_range(0, 39) == 0) begin hi_we = 1; wdata = 8'($urandom_range(0, 1)); end
      else if ($urandom_range(0, 49) == 0) begin
        cfg_we = 1; cfg_run = ($urandom_range(0, 3) != 0); cfg_irq_en = ($urandom_range(0, 3) != 0);
      end
      step();
      chk("R2 R4 random count", count, m_cnt);
      chk("R7 R8 random irq", {15'd0, irq}, {15'd0, m_flag & m_ie});
    end

    d_lo_we = 1; d_wdata = 8'hE8; step();
    d_hi_we = 1; d_wdata = 8'h03; step();
    chk("R9 div idle", d_count, 16'h0000);
    d_cfg_we = 1; d_run = 1; step();
    for (int i = 0; i < 30; i++) step();
    chk("R9 two ticks per three cycles", d_count, 16'd981);
    chk("R9 div masked irq", {15'd0, d_irq}, 16'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule